// File: doc/BRIEF.md
# Exclusive Two-Port Handshake Merge

This block joins two four-phase request/acknowledge channels on its input side onto one four-phase channel on its output side. The environment promises that the two input channels never request at the same time. Each rising input request starts exactly one complete output handshake. The acknowledge for that request goes back to the port that asked, and only to that port.

The return-to-zero half of each input handshake is decoupled from the output channel. The input request may fall, and its acknowledge may fall, while the output handshake is still finishing. So only rising edges carry meaning, and the output acknowledge must be back at zero before any new request is served. The block is a clocked, sampled circuit: every output is a register. A control state machine drives a small datapath through a struct of strobes. The datapath holds a sticky record of the port being served, so the acknowledge is always routed to that port.

Top module: `req_merge`

## Requirements
- R1: The bits of `portAck` are never both high. An acknowledge is only ever returned on the port whose request started the handshake in progress: bit 0 for port 0, bit 1 for port 1.
- R2: A request counts as pending when `portReq[i]` is high and `portAck[i]` is low. When the block is idle and samples a pending request, `outReq` rises on that same clock edge, so it is visible in the cycle after the request was applied.
- R3: While `outReq` is high, the edge that samples `outAck` high raises the served port's `portAck`. `outReq` stays high for that one cycle.
- R4: `outReq` falls on the clock edge after the one that raised the port acknowledge.
- R5: A raised `portAck[i]` stays high while `portReq[i]` is high. It falls on the edge that samples `portReq[i]` low, whatever the state of the output channel at that moment. This allows it to fall while `outAck` is still high.
- R6: After `outReq` falls, no new output request is raised until `outAck` has been sampled low. A request arriving in the meantime is held. It is served with `outReq` rising two edges after `outAck` is first applied low.
- R7: Each accepted request produces exactly one output handshake. A request that stays high after its acknowledge was given is not served again.
- R8: While `rstN` is low, `outReq` and both `portAck` bits are low. This holds even when a request is being served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portReq | input | NUM_PORTS | Request of each input channel, mutually exclusive |
| portAck | output | NUM_PORTS | Registered acknowledge of each input channel |
| outReq | output | 1 | Registered request on the merged output channel |
| outAck | input | 1 | Acknowledge of the merged output channel |

## Verification
The bound checker watches every cycle for the following:
- at most one port acknowledge is high at a time;
- `outReq` only rises after a pending request and only once `outAck` is low;
- a port acknowledge only rises after `outAck`, then falls exactly when its request is seen low, and otherwise holds;
- `outReq` drops only after an acknowledge has been given.

Some properties can only be shown by the bench's scenarios:
- there is exactly one output handshake per request, counted over the whole run;
- a request still held high after its acknowledge is not served a second time;
- a request from the other port that arrives during the output return-to-zero is delayed and then served;
- the input return-to-zero overlaps an output acknowledge that is still high.

// File: rtl/merge_pkg.sv
package merge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RAISE = 2'd1,
    PH_HOLD  = 2'd2,
    PH_RTZ   = 2'd3
  } phase_t;

  typedef struct packed {
    logic capture;
    logic setReq;
    logic clrReq;
    logic giveAck;
  } strobe_t;

endpackage

// File: rtl/merge_ctrl.sv
module merge_ctrl
  import merge_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    anyPending,
  input  logic    outAck,
  output strobe_t strobe
);

  phase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: begin
        if (anyPending) begin
          strobe.capture = 1'b1;
          strobe.setReq  = 1'b1;
          phaseNext      = PH_RAISE;
        end
      end
      PH_RAISE: begin
        if (outAck) begin
          strobe.giveAck = 1'b1;
          phaseNext      = PH_HOLD;
        end
      end
      PH_HOLD: begin
        strobe.clrReq = 1'b1;
        phaseNext     = PH_RTZ;
      end
      PH_RTZ: begin
        if (!outAck) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/merge_dpath.sv
module merge_dpath
  import merge_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] portReq,
  input  strobe_t              strobe,
  output logic [NUM_PORTS-1:0] portAck,
  output logic                 outReq,
  output logic                 anyPending
);

  logic [NUM_PORTS-1:0] pending;
  logic [NUM_PORTS-1:0] pickOne;
  logic [NUM_PORTS-1:0] servedSel;

  assign pending    = portReq & ~portAck;
  assign pickOne    = pending & (~pending + 1'b1);
  assign anyPending = |pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               servedSel <= '0;
    else if (strobe.capture) servedSel <= pickOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outReq <= 1'b0;
    else if (strobe.setReq) outReq <= 1'b1;
    else if (strobe.clrReq) outReq <= 1'b0;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_ack
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             portAck[i] <= 1'b0;
      else if (strobe.giveAck && servedSel[i]) portAck[i] <= 1'b1;
      else if (!portReq[i])                  portAck[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/req_merge.sv
module req_merge
  import merge_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] portReq,
  output logic [NUM_PORTS-1:0] portAck,
  output logic                 outReq,
  input  logic                 outAck
);

  strobe_t strobe;
  logic    anyPending;

  merge_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyPending(anyPending),
    .outAck    (outAck),
    .strobe    (strobe)
  );

  merge_dpath #(.NUM_PORTS(NUM_PORTS)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .portReq   (portReq),
    .strobe    (strobe),
    .portAck   (portAck),
    .outReq    (outReq),
    .anyPending(anyPending)
  );

endmodule

// File: rtl/req_merge_checker.sv
module req_merge_checker #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] portReq,
  input logic [NUM_PORTS-1:0] portAck,
  input logic                 outReq,
  input logic                 outAck
);

  assert_ack_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portAck));

  assert_req_after_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReq) |-> $past(|(portReq & ~portAck)));

  assert_ack_after_outack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(portAck & ~$past(portAck))) |-> ($past(outAck) && outReq));

  assert_drop_after_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outReq) |-> $past(|portAck));

  assert_wait_rtz_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReq) |-> !$past(outAck));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rstN)
      (portAck[i] && !portReq[i]) |=> !portAck[i]);
    assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (portAck[i] && portReq[i]) |=> portAck[i]);
  end

endmodule

bind req_merge req_merge_checker #(.NUM_PORTS(NUM_PORTS)) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .portReq(portReq),
  .portAck(portAck),
  .outReq (outReq),
  .outAck (outAck)
);

// File: tb/req_merge_test.sv
`timescale 1ns/1ps
module req_merge_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] portReq = '0;
  logic [1:0] portAck;
  logic       outReq;
  logic       outAck = 1'b0;

  int total = 0;
  int bad = 0;
  int handshakes = 0;
  int expHandshakes = 0;
  int cycles = 0;
  logic prevOutReq = 1'b0;
  logic bothSeen = 1'b0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  req_merge #(.NUM_PORTS(2)) uut (
    .clk    (clk),
    .rstN   (rstN),
    .portReq(portReq),
    .portAck(portAck),
    .outReq (outReq),
    .outAck (outAck)
  );

  always @(posedge clk) begin
    cycles++;
    if (&portReq) bothSeen = 1'b1;
    if (rstN && outReq && !prevOutReq) handshakes++;
    prevOutReq = outReq;
    if (cycles > 20000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // vector: [7:6] expected portAck, [5] port, [4] early release, [3:0] outAck delay
  localparam logic [7:0] VEC [6] = '{
    8'b01_0_0_0000,
    8'b10_1_0_0010,
    8'b01_0_1_0001,
    8'b10_1_1_0000,
    8'b01_0_1_0101,
    8'b10_1_0_0011
  };

  task automatic runTxn(int port, bit early, int delay, logic [1:0] expAck);
    portReq[port] = 1'b1;
    check("R2 outReq before edge", outReq, 0);
    step();
    check("R2 outReq raised", outReq, 1);
    expHandshakes++;
    for (int d = 0; d < delay; d++) step();
    check("R3 no ack before outAck", portAck, 0);
    outAck = 1'b1;
    step();
    check("R3/R1 ack routed", portAck, expAck);
    check("R3 outReq held", outReq, 1);
    step();
    check("R4 outReq dropped", outReq, 0);
    if (early) begin
      portReq[port] = 1'b0;
      step();
      check("R5 ack released while outAck high", portAck, 0);
      outAck = 1'b0;
      step();
      check("R6 idle outReq low", outReq, 0);
    end else begin
      outAck = 1'b0;
      step();
      step();
      check("R7 stale request not reserved", outReq, 0);
      check("R5 ack held while req high", portAck, expAck);
      portReq[port] = 1'b0;
      step();
      check("R5 ack released", portAck, 0);
    end
    step();
  endtask

  initial begin
    #1;
    check("R8 reset outReq", outReq, 0);
    check("R8 reset portAck", portAck, 0);
    step();
    rstN = 1'b1;
    step();
    check("R8 idle after reset", {portAck, outReq}, 0);

    for (int i = 0; i < 6; i++)
      runTxn(int'(VEC[i][5]), VEC[i][4], int'(VEC[i][3:0]), VEC[i][7:6]);

    // R6: port 1 requests while the output channel is still returning to zero
    portReq[0] = 1'b1;
    step();
    expHandshakes++;
    outAck = 1'b1;
    step();
    check("R1 port0 ack", portAck, 2'b01);
    portReq[0] = 1'b0;
    step();
    check("R5 ack0 fell with outReq", {portAck, outReq}, 0);
    portReq[1] = 1'b1;
    step();
    check("R6 held while outAck high", outReq, 0);
    step();
    check("R6 still held", {portAck, outReq}, 0);
    outAck = 1'b0;
    step();
    check("R6 not before idle", outReq, 0);
    step();
    check("R6 deferred request served", outReq, 1);
    expHandshakes++;
    outAck = 1'b1;
    step();
    check("R1 routed to port1", portAck, 2'b10);
    portReq[1] = 1'b0;
    step();
    check("R4 outReq dropped port1", outReq, 0);
    outAck = 1'b0;
    step();
    step();

    check("R7 one handshake per request", handshakes, expHandshakes);
    check("R1 env exclusive requests", bothSeen, 0);

    // R8: reset in the middle of a handshake
    portReq[0] = 1'b1;
    step();
    check("R2 before reset", outReq, 1);
    outAck = 1'b1;
    step();
    rstN = 1'b0;
    #1;
    check("R8 reset mid handshake", {portAck, outReq}, 0);
    portReq = '0;
    outAck = 1'b0;
    step();
    rstN = 1'b1;
    step();
    check("R8 quiet after reset", {portAck, outReq}, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule